// File: doc/BRIEF.md
# Serial DMA Request/Grant Host Engine

This block is the host end of a serial DMA channel-passing link. Each of its request/grant pairs carries one active-low request wire from a DMA expansion agent and one active-low grant wire back to it. The agent announces which DMA channels it wants by sending a short serial frame on its request wire: a low start sample, then one slot per channel. The block deserializes each frame, keeps only the channels that the style register assigns to this serial link, and stores them as pending requests.

When an eligible request is pending and no grant is in flight, the block raises a bus request. Once the system bus arbiter answers with a bus-granted pulse, the block picks the winning channel and pair and sends a four-sample grant frame on that pair's grant wire: a low start sample, then the three bits of the channel number. The grant stays open until the transfer engine reports completion. Completion clears the served request.

Top module: `sdma_link_host`

## Requirements
- R1: After reset every grant wire is high, all pending bits are 0, `grant_valid` is 0 and `bus_req` is 0.
- R2: A request frame starts at a low sample on a request wire. The next eight samples are slots for channels 0 to 7 in that order, and a slot sampled at 1 is a request. Requests from eligible channels appear in `pend` (pair p, channel c at bit 8*p+c) on the clock edge that samples slot 7.
- R3: Each channel c other than 4 has a 2-bit style field in `chan_style` at bits [2f+1:2f], where f=c for c<4 and f=c-1 for c>4. Only the value 2'b01 selects the serial link. A channel with any other value is never set pending and never granted, even if it was already pending when its field changed.
- R4: Channel 4 is the cascade channel. Its request slot is ignored and it is never pending.
- R5: A start is recognised only when the line was sampled high at least once since the previous frame ended or since reset. A line that stays low after a frame does not begin a new frame.
- R6: `bus_req` is 1 exactly when no grant is open and an eligible request is pending. A grant opens only on a clock edge where `bus_gnt` is 1.
- R7: The lowest eligible pending channel number wins. When both pairs hold the same winning channel, pair 0 wins.
- R8: The grant frame drives the winning pair's grant wire low for one cycle, then channel bit 0, bit 1 and bit 2, one cycle each, and then high. All other grant wires stay high.
- R9: `grant_valid`, `grant_pair` and `grant_chan` hold steady from the launch of a grant until its completion. No second grant opens while one is open.
- R10: `xfer_done` is accepted only after the grant frame has finished. It clears the served pending bit and closes the grant. `xfer_done` while the frame is still being sent has no effect.
- R11: If a frame sets the served channel on the same edge that `xfer_done` clears it, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | NPAIR | Serial request wires, one per pair |
| chan_style | input | 14 | Style fields for channels 0-3 and 5-7 |
| bus_gnt | input | 1 | Bus granted by the system arbiter |
| xfer_done | input | 1 | Transfer for the open grant has completed |
| gnt_n | output | NPAIR | Serial grant wires, one per pair |
| bus_req | output | 1 | Request for the system bus |
| pend | output | 8*NPAIR | Pending request bitmap, pair-major |
| grant_valid | output | 1 | A grant is open |
| grant_pair | output | max(1,clog2(NPAIR)) | Pair of the open grant |
| grant_chan | output | 3 | Channel of the open grant |

## Verification
Frame capture and grant completion can both act on one pending bit in the same clock edge. The bench times a request frame so that its slot-7 sample lands on the edge where `xfer_done` is accepted for the same channel. It then expects the bit to survive, the grant to close, and a fresh grant to follow. A second collision places `xfer_done` inside the grant frame, and the bench expects the frame to finish and the grant to stay open.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int NCH     = 8;
  localparam int CW      = $clog2(NCH);
  localparam int CASCADE = 4;
  localparam int SFW     = 2;
  localparam int STW     = SFW * (NCH - 1);
  localparam logic [SFW-1:0] STYLE_SERIAL = 2'b01;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_WAIT} tx_state_t;

  // Style field index for a channel; the cascade channel owns no field.
  function automatic int field_of(input int c);
    return (c < CASCADE) ? c : c - 1;
  endfunction

  function automatic logic [NCH-1:0] elig_mask(input logic [STW-1:0] style);
    logic [NCH-1:0] m;
    for (int c = 0; c < NCH; c++) begin
      if (c == CASCADE) m[c] = 1'b0;
      else m[c] = (style[field_of(c)*SFW +: SFW] == STYLE_SERIAL);
    end
    return m;
  endfunction

  function automatic logic [CW-1:0] lowest_idx(input logic [NCH-1:0] v);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) if (v[i]) r = CW'(i);
    return r;
  endfunction
endpackage

// File: rtl/sdma_req_rx.sv
module sdma_req_rx
  import sdma_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_line,
  output logic           frame_done,
  output logic [NCH-1:0] frame_bits
);
  logic           armed;
  logic           rx;
  logic [CW-1:0]  slot;
  logic [NCH-1:0] sr;

  assign frame_done = rx && (slot == CW'(NCH - 1));
  assign frame_bits = {req_line, sr[NCH-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      rx    <= 1'b0;
      slot  <= '0;
      sr    <= '0;
    end else if (rx) begin
      sr <= {req_line, sr[NCH-1:1]};
      if (frame_done) begin
        rx    <= 1'b0;
        armed <= 1'b0;
      end else begin
        slot <= slot + 1'b1;
      end
    end else if (req_line) begin
      armed <= 1'b1;
    end else if (armed) begin
      rx    <= 1'b1;
      armed <= 1'b0;
      slot  <= '0;
    end
  end
endmodule

// File: rtl/sdma_arb.sv
module sdma_arb
  import sdma_pkg::*;
#(
  parameter int NPAIR = 2,
  localparam int PW = (NPAIR > 1) ? $clog2(NPAIR) : 1
)(
  input  logic [NPAIR*NCH-1:0] pend,
  input  logic [NCH-1:0]       elig,
  output logic                 any,
  output logic [PW-1:0]        sel_pair,
  output logic [CW-1:0]        sel_chan
);
  logic [NCH-1:0] chan_hit;

  always_comb begin
    chan_hit = '0;
    for (int p = 0; p < NPAIR; p++) chan_hit = chan_hit | pend[p*NCH +: NCH];
    chan_hit = chan_hit & elig;
  end

  assign any      = |chan_hit;
  assign sel_chan = lowest_idx(chan_hit);

  always_comb begin
    sel_pair = '0;
    for (int p = NPAIR - 1; p >= 0; p--)
      if (pend[p*NCH + int'(sel_chan)]) sel_pair = PW'(p);
  end
endmodule

// File: rtl/sdma_gnt_tx.sv
module sdma_gnt_tx
  import sdma_pkg::*;
#(
  parameter int NPAIR = 2,
  localparam int PW = (NPAIR > 1) ? $clog2(NPAIR) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [PW-1:0]    launch_pair,
  input  logic [CW-1:0]    launch_chan,
  input  logic             done_in,
  output logic [NPAIR-1:0] gnt_n,
  output logic             busy,
  output logic [PW-1:0]    cur_pair,
  output logic [CW-1:0]    cur_chan,
  output logic             done_ev
);
  tx_state_t       st;
  logic            line_lvl;
  logic [CW-1:0]   sh;
  logic [1:0]      left;

  assign busy    = (st != TX_IDLE);
  assign done_ev = (st == TX_WAIT) && done_in;

  for (genvar p = 0; p < NPAIR; p++) begin : g_line
    assign gnt_n[p] = (cur_pair == PW'(p)) ? line_lvl : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      line_lvl <= 1'b1;
      sh       <= '0;
      left     <= '0;
      cur_pair <= '0;
      cur_chan <= '0;
    end else begin
      case (st)
        TX_IDLE: if (launch) begin
          st       <= TX_SEND;
          line_lvl <= 1'b0;
          sh       <= launch_chan;
          left     <= 2'(CW);
          cur_pair <= launch_pair;
          cur_chan <= launch_chan;
        end
        TX_SEND: if (left != 2'd0) begin
          line_lvl <= sh[0];
          sh       <= sh >> 1;
          left     <= left - 1'b1;
        end else begin
          line_lvl <= 1'b1;
          st       <= TX_WAIT;
        end
        TX_WAIT: if (done_in) st <= TX_IDLE;
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdma_link_host.sv
module sdma_link_host
  import sdma_pkg::*;
#(
  parameter int NPAIR = 2,
  localparam int PW = (NPAIR > 1) ? $clog2(NPAIR) : 1
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPAIR-1:0]     req_n,
  input  logic [STW-1:0]       chan_style,
  input  logic                 bus_gnt,
  input  logic                 xfer_done,
  output logic [NPAIR-1:0]     gnt_n,
  output logic                 bus_req,
  output logic [NPAIR*NCH-1:0] pend,
  output logic                 grant_valid,
  output logic [PW-1:0]        grant_pair,
  output logic [CW-1:0]        grant_chan
);
  logic [NCH-1:0] elig;
  logic           any;
  logic [PW-1:0]  sel_pair;
  logic [CW-1:0]  sel_chan;
  logic           launch;
  logic           done_ev;

  assign elig = elig_mask(chan_style);

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic           fdone;
    logic [NCH-1:0] fbits;
    logic [NCH-1:0] set_v;
    logic [NCH-1:0] clr_v;

    sdma_req_rx u_rx (
      .clk(clk), .rst_n(rst_n), .req_line(req_n[p]),
      .frame_done(fdone), .frame_bits(fbits)
    );

    assign set_v = fdone ? (fbits & elig) : '0;
    assign clr_v = (done_ev && grant_pair == PW'(p)) ? (NCH'(1) << grant_chan) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[p*NCH +: NCH] <= '0;
      else        pend[p*NCH +: NCH] <= (pend[p*NCH +: NCH] & ~clr_v) | set_v;
    end
  end

  sdma_arb #(.NPAIR(NPAIR)) u_arb (
    .pend(pend), .elig(elig), .any(any),
    .sel_pair(sel_pair), .sel_chan(sel_chan)
  );

  assign launch  = !grant_valid && bus_gnt && any;
  assign bus_req = !grant_valid && any;

  sdma_gnt_tx #(.NPAIR(NPAIR)) u_tx (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .launch_pair(sel_pair), .launch_chan(sel_chan), .done_in(xfer_done),
    .gnt_n(gnt_n), .busy(grant_valid), .cur_pair(grant_pair),
    .cur_chan(grant_chan), .done_ev(done_ev)
  );
endmodule

// File: rtl/sdma_link_host_chk.sv
module sdma_link_host_chk
  import sdma_pkg::*;
#(
  parameter int NPAIR = 2
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NPAIR-1:0]     gnt_n,
  input logic [NPAIR*NCH-1:0] pend,
  input logic                 bus_gnt,
  input logic                 grant_valid,
  input logic [CW-1:0]        grant_chan,
  input logic                 done_ev
);
  // R8: grant wires stay high while no grant is open
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (&gnt_n));

  // R8: at most one grant wire is low at a time
  a_r8_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  // R6: a grant opens only after the bus was granted
  a_r6_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> $past(bus_gnt));

  // R9: an open grant keeps its channel until completion
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !done_ev) |=> (grant_valid && $stable(grant_chan)));

  // R10: completion closes the grant
  a_r10_close: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !grant_valid);

  for (genvar p = 0; p < NPAIR; p++) begin : g_cas
    // R4: the cascade channel never becomes pending
    a_r4_no_cascade: assert property (@(posedge clk) disable iff (!rst_n)
      !pend[p*NCH + CASCADE]);
  end
endmodule

bind sdma_link_host sdma_link_host_chk #(.NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt_n(gnt_n), .pend(pend), .bus_gnt(bus_gnt),
  .grant_valid(grant_valid), .grant_chan(grant_chan), .done_ev(done_ev)
);

// File: tb/test_sdma_link_host.sv
module test_sdma_link_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req_n = 2'b11;
  logic [13:0] chan_style = 14'h1555;
  logic        bus_gnt = 1'b0;
  logic        xfer_done = 1'b0;
  logic [1:0]  gnt_n;
  logic        bus_req;
  logic [15:0] pend;
  logic        grant_valid;
  logic [0:0]  grant_pair;
  logic [2:0]  grant_chan;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sdma_link_host #(.NPAIR(2)) i_sdma_link_host (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .chan_style(chan_style),
    .bus_gnt(bus_gnt), .xfer_done(xfer_done), .gnt_n(gnt_n), .bus_req(bus_req),
    .pend(pend), .grant_valid(grant_valid), .grant_pair(grant_pair),
    .grant_chan(grant_chan)
  );

  // {style14, reqA, reqB, expA, expB, pair, chan}
  localparam int VN = 7;
  localparam logic [49:0] VEC [VN] = '{
    {14'h1555, 8'h42, 8'h00, 8'h42, 8'h00, 1'b0, 3'd1},
    {14'h1555, 8'h00, 8'h40, 8'h00, 8'h40, 1'b1, 3'd6},
    {14'h1555, 8'h10, 8'h80, 8'h00, 8'h80, 1'b1, 3'd7},
    {14'h1554, 8'h09, 8'h01, 8'h08, 8'h00, 1'b0, 3'd3},
    {14'h1555, 8'h20, 8'h04, 8'h20, 8'h04, 1'b1, 3'd2},
    {14'h1555, 8'h08, 8'h08, 8'h08, 8'h08, 1'b0, 3'd3},
    {14'h2555, 8'h80, 8'h81, 8'h00, 8'h01, 1'b1, 3'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_n = 2'b11; bus_gnt = 1'b0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_frames(input logic [7:0] a, input logic [7:0] b, input bit done_last);
    @(negedge clk) req_n = 2'b11;
    @(negedge clk) req_n = 2'b00;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      req_n = {b[i], a[i]};
      if (i == 7 && done_last) xfer_done = 1'b1;
    end
    @(negedge clk);
    req_n = 2'b11;
    xfer_done = 1'b0;
  endtask

  // Opens a grant at the current negedge and checks the whole grant frame (R8).
  task automatic open_grant(input logic p, input logic [2:0] c, input string tag);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    check({tag, " R9 valid"}, grant_valid, 1);
    check({tag, " R7 pair"}, grant_pair, p);
    check({tag, " R7 chan"}, grant_chan, c);
    check({tag, " R8 start"}, gnt_n, p ? 2'b01 : 2'b10);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check({tag, " R8 bit"}, gnt_n[p], c[k]);
      check({tag, " R8 other"}, gnt_n[~p], 1);
    end
    @(negedge clk);
    check({tag, " R8 end high"}, gnt_n, 2'b11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 gnt_n", gnt_n, 2'b11);
    check("R1 pend", pend, 0);
    check("R1 grant_valid", grant_valid, 0);
    check("R1 bus_req", bus_req, 0);

    // Vector table: R2, R3, R4, R6, R7, R8, R10
    for (int v = 0; v < VN; v++) begin
      logic [49:0] e;
      logic [15:0] ep;
      e = VEC[v];
      do_reset();
      chan_style = e[49:36];
      send_frames(e[35:28], e[27:20], 1'b0);
      ep = {e[11:4], e[19:12]};
      check("R2 R3 R4 pending", pend, ep);
      check("R6 bus_req", bus_req, |ep);
      if (|ep) begin
        open_grant(e[3], e[2:0], "vec");
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        ep[{e[3], e[2:0]}] = 1'b0;
        check("R10 closed", grant_valid, 0);
        check("R10 cleared", pend, ep);
      end
    end

    // R5: a line held low after a frame must not start a new frame
    do_reset();
    chan_style = 14'h1555;
    @(negedge clk) req_n = 2'b11;
    @(negedge clk) req_n = 2'b10;
    for (int i = 0; i < 8; i++) @(negedge clk) req_n = 2'b10;
    @(negedge clk) req_n = 2'b10;
    for (int i = 0; i < 12; i++) @(negedge clk) req_n = 2'b11;
    check("R5 no false start", pend, 0);

    // R3: style change removes an already pending channel from service
    do_reset();
    chan_style = 14'h1555;
    send_frames(8'h01, 8'h00, 1'b0);
    check("R3 pending before", pend, 16'h0001);
    chan_style = 14'h1554;
    @(negedge clk);
    check("R3 bus_req masked", bus_req, 0);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    check("R3 no grant", grant_valid, 0);
    check("R3 gnt_n idle", gnt_n, 2'b11);

    // R10: completion during the grant frame is ignored
    do_reset();
    chan_style = 14'h1555;
    send_frames(8'h02, 8'h00, 1'b0);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 early done ignored valid", grant_valid, 1);
    check("R10 early done ignored pend", pend, 16'h0002);
    check("R10 frame finished", gnt_n, 2'b11);

    // R9 and R11: new requests while a grant is open, then a same-edge collision
    bus_gnt = 1'b1;
    send_frames(8'h01, 8'h00, 1'b0);
    check("R9 still open", grant_valid, 1);
    check("R9 chan held", grant_chan, 1);
    check("R9 pend merged", pend, 16'h0003);
    send_frames(8'h02, 8'h00, 1'b1);
    check("R11 bit kept", pend, 16'h0003);
    check("R11 grant closed", grant_valid, 0);
    @(negedge clk);
    bus_gnt = 1'b0;
    check("R7 next grant lowest", grant_chan, 0);
    check("R7 next grant valid", grant_valid, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule